// File: doc/BRIEF.md
# DMA Request Hold and RAM Window Guard

This block is the sequencer of one DMA channel inside a small microcontroller. Each accepted request moves one unit, a byte or a 16-bit word, between a fixed peripheral register address and a RAM address that steps forward after every unit. A direction bit picks whether data goes from the peripheral into RAM or from RAM out to the peripheral. The channel asks for the bus and moves nothing until the bus grants it. It then performs one read cycle and one write cycle.

The CPU reports each instruction boundary. At that boundary it also says whether the instruction just completed belongs to a class after which DMA must not start: calls, software breaks, bit operations on the interrupt control or status registers, and data-flash accesses. A pending request waits for the next boundary that carries no such flag. Each RAM address is checked against a window. The window runs from a programmable low bound up to a fixed top that lies just below the register bank hole and the peripheral space. Out-of-window transfers are suppressed or replaced with a filler value. Separately, when a data-flash read is the second instruction after a transfer starts, the CPU receives a three-cycle wait.

Top module: `dma_hold_guard`

## Requirements
- R1: A pending request starts a unit only in a cycle where `cpu_instr_done` is 1 and `cpu_instr_hold` is 0. A boundary with the hold flag set, or a cycle with no boundary, keeps the request pending. The bus request rises in the cycle after the start.
- R2: Requests that arrive before the pending one is serviced merge with it, so several pulses yield one unit.
- R3: After a start, `bus_req` stays high and no read or write strobe is issued until `bus_gnt` is seen. A read cycle follows the grant, then a write cycle. The two strobes are never high together.
- R4: After each unit the RAM address advances by 1 in byte mode or 2 in word mode. The peripheral address does not change.
- R5: A RAM address is inside the window when it is at or above the programmed low bound and its last byte (the address plus 1 in word mode) is at or below 20'hFFEDF.
- R6: In peripheral-to-RAM mode (`cfg_ram2per`=0), an out-of-window RAM address gets no write strobe. The unit still counts.
- R7: In RAM-to-peripheral mode (`cfg_ram2per`=1), an out-of-window RAM address gets no read strobe. The peripheral is still written, with the filler 16'hA5A5, and `win_err` is set. `win_err` stays set until the next configuration load or reset.
- R8: Each unit decrements the transfer count. `xfer_done` is a one-cycle pulse after the unit that brings the count to zero. No unit starts while the count is zero or `cfg_en` is 0. A request stays pending until `cfg_en` returns.
- R9: A transfer start begins instruction 1. The next boundary begins instruction 2. If `cpu_flash_rd` is high while instruction 2 runs, `cpu_wait` is high for exactly 3 cycles, starting the cycle after. A flash read during instruction 1, or after instruction 2 has ended, causes no wait.
- R10: A synchronous active-low reset clears the pending request, the counters, `win_err`, `xfer_done` and the wait counter.
- R11: In byte mode only bits 7:0 of the read data are moved, and bits 15:8 of the written data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Loads the configuration fields while the channel is idle |
| cfg_en | input | 1 | Channel enable |
| cfg_ram2per | input | 1 | 1: RAM to peripheral, 0: peripheral to RAM |
| cfg_word | input | 1 | 1: 16-bit units, 0: byte units |
| cfg_ram_addr | input | 20 | Start RAM address |
| cfg_per_addr | input | 20 | Fixed peripheral register address |
| cfg_count | input | 16 | Number of units |
| cfg_win_lo | input | 20 | Low bound of the RAM window |
| dma_req | input | 1 | Transfer request pulse |
| cpu_instr_done | input | 1 | An instruction completes this cycle |
| cpu_instr_hold | input | 1 | The completing instruction is of a hold class |
| cpu_flash_rd | input | 1 | The running instruction reads data flash |
| cpu_wait | output | 1 | Stall request to the CPU |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_word | output | 1 | Access width, 1 for word |
| mem_addr | output | 20 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the read cycle |
| xfer_done | output | 1 | Final unit completed |
| win_err | output | 1 | Sticky: filler was sent to the peripheral |

## Verification
The bench uses the default parameters: a 20-bit address, 16-bit data, a window top of 20'hFFEDF, filler 16'hA5A5 and a 3-cycle wait. It programs the low bound to 20'hFE000. Under that setup, one short unit can reach the top edge of the window, the register bank hole, peripheral space and the area below the low bound. A word placed at the last in-window byte shows that the straddle rule works, and a 16-bit count leaves room for short merged runs.

// File: rtl/dmahg_pkg.sv
package dmahg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } unit_st_e;
endpackage

// File: rtl/dmahg_req_hold.sv
module dmahg_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    input  logic instr_done_i,
    input  logic instr_hold_i,
    output logic pend_o,
    output logic slot_o
);
    logic pend_d, pend_q;

    always_comb begin
        // a fresh pulse in the service cycle is a new request
        pend_d = (pend_q & ~take_i) | req_i;
        slot_o = instr_done_i & ~instr_hold_i;
        pend_o = pend_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/dmahg_win_chk.sv
module dmahg_win_chk #(
    parameter int            AW      = 20,
    parameter logic [AW-1:0] WIN_TOP = 20'hFFEDF
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] lo_i,
    input  logic          word_i,
    output logic          in_win_o
);
    logic [AW:0] last_byte;

    always_comb begin
        last_byte = {1'b0, addr_i} + (AW+1)'(word_i);
        in_win_o  = (addr_i >= lo_i) && (last_byte <= {1'b0, WIN_TOP});
    end
endmodule

// File: rtl/dmahg_flash_wait.sv
module dmahg_flash_wait #(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic instr_done_i,
    input  logic flash_rd_i,
    output logic wait_o
);
    localparam int WW = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        logic [1:0]    idx;
        logic [WW-1:0] wcnt;
    } fw_t;

    fw_t d, q;

    always_comb begin
        d = q;
        if (q.wcnt != '0) d.wcnt = q.wcnt - WW'(1);
        if (start_i) begin
            d.idx = 2'd1;
        end else if (q.idx == 2'd2 && flash_rd_i) begin
            d.idx  = 2'd0;
            d.wcnt = WW'(WAIT_CYC);
        end else if (instr_done_i && q.idx != 2'd0) begin
            d.idx = (q.idx == 2'd1) ? 2'd2 : 2'd0;
        end
        wait_o = (q.wcnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dma_hold_guard.sv
module dma_hold_guard
    import dmahg_pkg::*;
#(
    parameter int            AW       = 20,
    parameter int            DW       = 16,
    parameter int            CW       = 16,
    parameter logic [AW-1:0] WIN_TOP  = 20'hFFEDF,
    parameter logic [DW-1:0] FILL_VAL = 16'hA5A5,
    parameter int            WAIT_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic          cfg_en,
    input  logic          cfg_ram2per,
    input  logic          cfg_word,
    input  logic [AW-1:0] cfg_ram_addr,
    input  logic [AW-1:0] cfg_per_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_win_lo,
    input  logic          dma_req,
    input  logic          cpu_instr_done,
    input  logic          cpu_instr_hold,
    input  logic          cpu_flash_rd,
    output logic          cpu_wait,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          xfer_done,
    output logic          win_err
);
    localparam int          BW     = 8;
    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_W = AW'(DW / BW);

    typedef struct packed {
        unit_st_e      st;
        logic [AW-1:0] ram_a;
        logic [AW-1:0] per_a;
        logic [AW-1:0] win_lo;
        logic [CW-1:0] cnt;
        logic          r2p;
        logic          word;
        logic          in_win;
        logic [DW-1:0] data;
        logic          err;
        logic          done;
    } seq_t;

    seq_t d, q;
    logic pend, slot, unit_go, win_ok;
    logic dir_r2p_w;

    assign dir_r2p_w = q.r2p;

    assign unit_go = (q.st == ST_IDLE) && !cfg_load && pend && slot
                     && cfg_en && (q.cnt != '0);

    dmahg_req_hold u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (dma_req),
        .take_i       (unit_go),
        .instr_done_i (cpu_instr_done),
        .instr_hold_i (cpu_instr_hold),
        .pend_o       (pend),
        .slot_o       (slot)
    );

    dmahg_win_chk #(.AW(AW), .WIN_TOP(WIN_TOP)) u_win (
        .addr_i   (q.ram_a),
        .lo_i     (q.win_lo),
        .word_i   (q.word),
        .in_win_o (win_ok)
    );

    dmahg_flash_wait #(.WAIT_CYC(WAIT_CYC)) u_fwait (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (unit_go),
        .instr_done_i (cpu_instr_done),
        .flash_rd_i   (cpu_flash_rd),
        .wait_o       (cpu_wait)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        bus_req   = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_word  = q.word;
        mem_addr  = '0;
        mem_wdata = q.data;
        unique case (q.st)
            ST_IDLE: begin
                if (cfg_load) begin
                    d.ram_a  = cfg_ram_addr;
                    d.per_a  = cfg_per_addr;
                    d.win_lo = cfg_win_lo;
                    d.cnt    = cfg_count;
                    d.r2p    = cfg_ram2per;
                    d.word   = cfg_word;
                    d.err    = 1'b0;
                end else if (unit_go) begin
                    d.st     = ST_GRANT;
                    d.in_win = win_ok;
                end
            end
            ST_GRANT: begin
                bus_req = 1'b1;
                if (bus_gnt) d.st = ST_READ;
            end
            ST_READ: begin
                bus_req  = 1'b1;
                mem_addr = q.r2p ? q.ram_a : q.per_a;
                if (q.r2p && !q.in_win) begin
                    d.data = FILL_VAL;
                    d.err  = 1'b1;
                end else begin
                    mem_rd = 1'b1;
                    d.data = q.word ? mem_rdata
                                    : {{(DW-BW){1'b0}}, mem_rdata[BW-1:0]};
                end
                d.st = ST_WRITE;
            end
            ST_WRITE: begin
                bus_req  = 1'b1;
                mem_addr = q.r2p ? q.per_a : q.ram_a;
                mem_wr   = q.r2p || q.in_win;
                d.ram_a  = q.ram_a + (q.word ? STEP_W : STEP_B);
                d.cnt    = q.cnt - CW'(1);
                d.done   = (q.cnt == CW'(1));
                d.st     = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign xfer_done = q.done;
    assign win_err   = q.err;
endmodule

// File: rtl/dmahg_chk.sv
module dmahg_chk #(
    parameter int            AW      = 20,
    parameter logic [AW-1:0] WIN_TOP = 20'hFFEDF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_instr_done,
    input logic          cpu_instr_hold,
    input logic          cpu_flash_rd,
    input logic          cpu_wait,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          xfer_done,
    input logic          win_err,
    input logic          dir_r2p
);
    // R1
    start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(cpu_instr_done) && !$past(cpu_instr_hold));

    // R3
    grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(bus_gnt) && $past(bus_req));

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6
    ram_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !dir_r2p) |-> (mem_addr <= WIN_TOP));

    // R7
    fill_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_err) |-> !$past(mem_rd) && $past(bus_req));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R9
    wait_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_wait) |-> $past(cpu_flash_rd));

    // R9
    wait_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_wait) |=> cpu_wait);

    // R9
    wait_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && $past(cpu_wait) && $past(cpu_wait, 2)) |=> !cpu_wait);

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !bus_req && !cpu_wait && !win_err && !xfer_done);
endmodule

bind dma_hold_guard dmahg_chk #(.AW(AW), .WIN_TOP(WIN_TOP)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_instr_done (cpu_instr_done),
    .cpu_instr_hold (cpu_instr_hold),
    .cpu_flash_rd   (cpu_flash_rd),
    .cpu_wait       (cpu_wait),
    .bus_req        (bus_req),
    .bus_gnt        (bus_gnt),
    .mem_rd         (mem_rd),
    .mem_wr         (mem_wr),
    .mem_addr       (mem_addr),
    .xfer_done      (xfer_done),
    .win_err        (win_err),
    .dir_r2p        (dir_r2p_w)
);

// File: tb/tb_dma_hold_guard.sv
`timescale 1ns/1ps
module tb_dma_hold_guard;
    localparam logic [19:0] PER  = 20'hFFF20;
    localparam logic [19:0] LO   = 20'hFE000;
    localparam logic [15:0] FILL = 16'hA5A5;

    // {ram2per, word, ram address, expected in-window}
    localparam logic [22:0] VECS [0:8] = '{
        {1'b0, 1'b0, 20'hFE100, 1'b1},   // R11 byte into RAM
        {1'b0, 1'b1, 20'hFFEDE, 1'b1},   // R5 word ending on top
        {1'b0, 1'b1, 20'hFFEDF, 1'b0},   // R5 word straddling top
        {1'b0, 1'b0, 20'hFFEE0, 1'b0},   // R6 register bank
        {1'b0, 1'b0, 20'hFFF10, 1'b0},   // R6 peripheral space
        {1'b1, 1'b0, 20'hFFEDF, 1'b1},   // R11 byte out of RAM
        {1'b1, 1'b1, 20'hFFEF0, 1'b0},   // R7 bank as source
        {1'b0, 1'b0, 20'hFD000, 1'b0},   // R5 below low bound
        {1'b1, 1'b0, 20'hFDFFF, 1'b0}    // R7 below low bound
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_load = 0, cfg_en = 1, cfg_ram2per = 0, cfg_word = 0;
    logic [19:0] cfg_ram_addr = '0, cfg_per_addr = PER, cfg_win_lo = LO;
    logic [15:0] cfg_count = '0;
    logic dma_req = 0, cpu_instr_done = 1, cpu_instr_hold = 0, cpu_flash_rd = 0;
    logic gnt_allow = 1;
    logic cpu_wait, bus_req, bus_gnt, mem_rd, mem_wr, mem_word;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic xfer_done, win_err;

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, req_cyc = 0;
    logic [19:0] first_wr, last_wr, last_rd;
    logic [15:0] last_wd;
    bit finished = 0;

    always #2 clk = ~clk;

    assign bus_gnt   = bus_req & gnt_allow;
    assign mem_rdata = mem_addr[15:0] ^ 16'h3C3C;

    dma_hold_guard dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_en(cfg_en),
        .cfg_ram2per(cfg_ram2per), .cfg_word(cfg_word),
        .cfg_ram_addr(cfg_ram_addr), .cfg_per_addr(cfg_per_addr),
        .cfg_count(cfg_count), .cfg_win_lo(cfg_win_lo), .dma_req(dma_req),
        .cpu_instr_done(cpu_instr_done), .cpu_instr_hold(cpu_instr_hold),
        .cpu_flash_rd(cpu_flash_rd), .cpu_wait(cpu_wait), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .xfer_done(xfer_done), .win_err(win_err)
    );

    always @(negedge clk) if (rst_n) begin
        if (bus_req) req_cyc++;
        if (mem_rd) begin rd_cnt++; last_rd = mem_addr; end
        if (mem_wr) begin
            if (wr_cnt == 0) first_wr = mem_addr;
            wr_cnt++; last_wr = mem_addr; last_wd = mem_wdata;
        end
        if (xfer_done) done_cnt++;
    end

    function automatic logic [15:0] bus_val(input logic [19:0] a, input logic w);
        logic [15:0] v;
        v = a[15:0] ^ 16'h3C3C;
        return w ? v : {8'h00, v[7:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        wr_cnt = 0; rd_cnt = 0; done_cnt = 0; req_cyc = 0;
    endtask

    task automatic load(input logic r2p, input logic w, input logic [19:0] ra,
                        input logic [15:0] cnt);
        @(negedge clk);
        cfg_ram2per = r2p; cfg_word = w; cfg_ram_addr = ra; cfg_count = cnt;
        cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic pulse_req();
        dma_req = 1; cyc(1); dma_req = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        report();
    end

    initial begin
        cyc(4);
        rst_n = 1;
        cyc(1);
        // R10 reset state
        check("R10 bus_req", bus_req, 0);
        check("R10 cpu_wait", cpu_wait, 0);
        check("R10 win_err", win_err, 0);
        check("R10 xfer_done", xfer_done, 0);

        // window / direction table
        for (int i = 0; i < 9; i++) begin
            automatic logic r2p = VECS[i][22];
            automatic logic w = VECS[i][21];
            automatic logic [19:0] ra = VECS[i][20:1];
            automatic logic inw = VECS[i][0];
            automatic string t = $sformatf("R5/R6/R7 vec%0d", i);
            load(r2p, w, ra, 16'd1);
            clr();
            pulse_req();
            cyc(8);
            check({t, " wr"}, wr_cnt, (r2p || inw) ? 1 : 0);
            check({t, " rd"}, rd_cnt, (r2p && !inw) ? 0 : 1);
            check({t, " err"}, win_err, r2p && !inw);
            check({t, " R8 done"}, done_cnt, 1);
            if (r2p) begin
                check({t, " addr"}, last_wr, PER);
                check({t, " R11 data"}, last_wd, inw ? bus_val(ra, w) : FILL);
            end else if (inw) begin
                check({t, " addr"}, last_wr, ra);
                check({t, " R11 data"}, last_wd, bus_val(PER, w));
            end
        end
        // R7 err stays until reload
        check("R7 sticky", win_err, 1);

        // R1 hold flag and missing boundary
        load(0, 0, 20'hFE300, 16'd1);
        clr();
        cpu_instr_hold = 1;
        pulse_req();
        for (int k = 0; k < 4; k++) begin
            check("R1 held", bus_req, 0);
            cyc(1);
        end
        cpu_instr_hold = 0; cpu_instr_done = 0;
        cyc(3);
        check("R1 no boundary", bus_req, 0);
        cpu_instr_done = 1;
        cyc(1);
        check("R1 start at clean boundary", bus_req, 1);
        cyc(6);
        check("R1 unit done", wr_cnt, 1);

        // R2 merge, R4 byte step, R8 count
        load(0, 0, 20'hFE400, 16'd2);
        clr();
        cpu_instr_hold = 1;
        pulse_req(); cyc(1); pulse_req(); cyc(1); pulse_req();
        cpu_instr_hold = 0;
        cyc(8);
        check("R2 merged one unit", wr_cnt, 1);
        check("R8 no done yet", done_cnt, 0);
        pulse_req();
        cyc(8);
        check("R2 second unit", wr_cnt, 2);
        check("R8 done on last", done_cnt, 1);
        check("R4 byte step", last_wr, 20'hFE401);

        // R4 word step, peripheral fixed
        load(0, 1, 20'hFE200, 16'd2);
        clr();
        pulse_req(); cyc(8);
        pulse_req(); cyc(8);
        check("R4 first addr", first_wr, 20'hFE200);
        check("R4 word step", last_wr, 20'hFE202);
        check("R4 per fixed", last_rd, PER);
        check("R4 two reads", rd_cnt, 2);

        // R8 zero count
        load(0, 0, 20'hFE500, 16'd0);
        clr();
        pulse_req(); cyc(6);
        check("R8 zero count", req_cyc, 0);

        // R8 enable low keeps request pending
        cfg_en = 0;
        load(0, 0, 20'hFE500, 16'd1);
        clr();
        pulse_req(); cyc(6);
        check("R8 disabled", req_cyc, 0);
        cfg_en = 1;
        cyc(8);
        check("R8 pending served", wr_cnt, 1);

        // R3 grant required
        gnt_allow = 0;
        load(0, 0, 20'hFE600, 16'd1);
        clr();
        pulse_req(); cyc(6);
        check("R3 req held", bus_req, 1);
        check("R3 no read", rd_cnt, 0);
        gnt_allow = 1;
        cyc(6);
        check("R3 moves after grant", wr_cnt, 1);

        // R9 flash wait on second instruction
        load(0, 0, 20'hFE700, 16'd3);
        cpu_instr_done = 0;
        pulse_req();
        cpu_instr_done = 1;
        cyc(1);              // start
        cyc(1);              // boundary: instruction 2 begins
        cpu_instr_done = 0; cpu_flash_rd = 1;
        cyc(1);
        cpu_flash_rd = 0;
        check("R9 wait c1", cpu_wait, 1);
        cyc(1); check("R9 wait c2", cpu_wait, 1);
        cyc(1); check("R9 wait c3", cpu_wait, 1);
        cyc(1); check("R9 wait end", cpu_wait, 0);

        // R9 flash read as first instruction
        pulse_req();
        cpu_instr_done = 1;
        cyc(1);              // start
        cpu_instr_done = 0; cpu_flash_rd = 1;
        cyc(1);
        cpu_flash_rd = 0;
        for (int k = 0; k < 3; k++) begin
            check("R9 first instr no wait", cpu_wait, 0);
            cyc(1);
        end

        // R9 flash read as third instruction
        pulse_req();
        cpu_instr_done = 1;
        cyc(1);              // start
        cyc(1);              // instruction 2
        cyc(1);              // instruction 3
        cpu_instr_done = 0; cpu_flash_rd = 1;
        cyc(1);
        cpu_flash_rd = 0; cpu_instr_done = 1;
        for (int k = 0; k < 3; k++) begin
            check("R9 third instr no wait", cpu_wait, 0);
            cyc(1);
        end
        cyc(4);

        // R10 reset clears err and pending request
        load(1, 0, 20'hFFEE4, 16'd1);
        pulse_req(); cyc(8);
        check("R10 err set before reset", win_err, 1);
        cpu_instr_hold = 1;
        pulse_req();
        rst_n = 0;
        cyc(2);
        rst_n = 1;
        cpu_instr_hold = 0;
        cyc(1);
        check("R10 err cleared", win_err, 0);
        check("R10 bus idle", bus_req, 0);
        clr();
        load(0, 0, 20'hFE800, 16'd1);
        cyc(5);
        check("R10 pending cleared", req_cyc, 0);

        report();
    end
endmodule